// File: doc/BRIEF.md
# Halt Standby Controller

This block owns the low-power halt sequence of a processor subsystem. When the core raises a halt request, the 2-bit mode field picks one of three sleep depths: only the core clock stops, only the oscillator keeps running, or every domain including the oscillator stops. The block drives one run enable per domain (core, peripheral clock tree, oscillator), and these enables are what gate the clocks.

While asleep, the block compares each incoming interrupt request against the current interrupt mask. It then decides whether to wake and how the core should continue. A request at or above the mask wakes the core and is taken. A request below the mask normally leaves the core asleep. A small set of designated external lines is the exception: they wake the core without being taken, so execution simply continues after the halt. The non-maskable request always wakes the core and is taken. Leaving the deepest state first restarts the oscillator and waits a warm-up time. That time is a power of two, chosen by a code that is captured together with the halt request.

Requests arrive from other clock domains. They are resynchronised before any decision is made, so the wake itself always lands on a clock edge. A one-cycle action code tells the core what to do on the cycle its clock returns.

Top module: `halt_standby_ctrl`

## Requirements
- R1: While running, a halt_req_i pulse sampled on a rising edge moves the block into a halt state on that edge, selected by halt_mode_i. The run enables (cpu, io, osc) become 0,1,1 for mode 2'b11, 0,0,1 for mode 2'b10, and 0,0,0 for mode 2'b01.
- R2: A halt request with mode 2'b00 is ignored, and the block stays running. A halt request that arrives while the block is already halted is also ignored, and the run enables do not change.
- R3: A synchronised request on line k whose level (irq_lvl_i[k*LVL_W +: LVL_W]) is greater than or equal to irq_mask_i wakes the block with wake_act_o = 2'b01 (service). This applies in every halt mode.
- R4: A request below the mask on a line whose bit in EXT_WAKE is 0 does not wake the block. The block stays halted for as long as that request is the only one present.
- R5: A request below the mask on a line whose EXT_WAKE bit is 1 wakes the block with wake_act_o = 2'b10 (resume without service). When a wake qualifies for both service and resume, service wins.
- R6: nmi_i wakes the block with wake_act_o = 2'b01 from every halt mode, whatever the mask.
- R7: Requests pass through two synchronising flops. In modes 2'b11 and 2'b10, the run enables come back on the third rising edge after a request goes high between edges.
- R8: In mode 2'b01 a wake first enters a warm-up phase, in which only osc_run_o is 1. The warm-up lasts 2^WARM_EXP1, 2^WARM_EXP2 or 2^WARM_EXP3 cycles for warm_sel_i codes 01, 10 and 11; code 00 behaves like 01. warm_sel_i is captured at halt entry. With a warm-up of N cycles, the run enables return on the (3+N)th rising edge after the request goes high.
- R9: wake_act_o is nonzero for exactly one cycle: the first cycle in which cpu_run_o is high again. It is 2'b00 at all other times and never 2'b11.
- R10: Asserting rst_ni low releases any halt state at once. All run enables go to 1 and wake_act_o goes to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Halt request pulse from the core |
| halt_mode_i | input | 2 | Halt depth: 11 core only, 10 oscillator only, 01 full stop, 00 reserved |
| warm_sel_i | input | 2 | Warm-up length code, captured at halt entry |
| irq_i | input | NUM_IRQ | Maskable interrupt requests, asynchronous |
| irq_lvl_i | input | NUM_IRQ*LVL_W | Priority level of each request line |
| irq_mask_i | input | LVL_W | Current interrupt mask level |
| nmi_i | input | 1 | Non-maskable request, asynchronous |
| cpu_run_o | output | 1 | Core clock enable |
| io_run_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator enable |
| wake_act_o | output | 2 | Wake action: 00 none, 01 service, 10 resume |

## Verification
The bench builds the block with four request lines, two of them designated as resume-only wake lines, and warm-up exponents of 2, 3 and 4. With these values it can sweep every mode, every line, every level from 1 to 7 and every mask from 0 to 7, and it rotates through all four warm-up codes. Because the warm-ups are short, the exact wake edge can be counted for each combination. Cases that must not wake are held asleep and then freed by the non-maskable request. Separate runs cover the reserved mode, a request repeated while halted, and reset applied in the middle of a halt.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE_CPU,
    ST_IDLE_OSC,
    ST_STOP,
    ST_WARM
  } hstate_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'b00,
    ACT_SERVICE = 2'b01,
    ACT_RESUME  = 2'b10
  } wake_act_e;

  localparam logic [1:0] MODE_RSVD = 2'b00;
  localparam logic [1:0] MODE_ALL  = 2'b01;
  localparam logic [1:0] MODE_OSC  = 2'b10;
  localparam logic [1:0] MODE_CPU  = 2'b11;
endpackage

// File: rtl/halt_irq_sync.sv
module halt_irq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/halt_wake_eval.sv
module halt_wake_eval
  import halt_pkg::*;
#(
  parameter int                 NUM_IRQ  = 16,
  parameter int                 LVL_W    = 3,
  parameter logic [NUM_IRQ-1:0] EXT_WAKE = '0
) (
  input  logic [NUM_IRQ-1:0]       irq_s_i,
  input  logic                     nmi_s_i,
  input  logic [NUM_IRQ*LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0]         mask_i,
  output logic                     wake_o,
  output wake_act_e                act_o
);
  logic [NUM_IRQ-1:0] hit_svc;
  logic [NUM_IRQ-1:0] hit_res;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    assign hit_svc[k] = irq_s_i[k] && (lvl_i[k*LVL_W +: LVL_W] >= mask_i);
    assign hit_res[k] = irq_s_i[k] && EXT_WAKE[k];
  end

  logic svc;
  logic res;
  assign svc = nmi_s_i || (|hit_svc);
  assign res = |hit_res;

  always_comb begin
    wake_o = svc || res;
    if (svc)      act_o = ACT_SERVICE;
    else if (res) act_o = ACT_RESUME;
    else          act_o = ACT_NONE;
  end
endmodule

// File: rtl/halt_warm_timer.sv
module halt_warm_timer #(
  parameter int WARM_EXP1 = 8,
  parameter int WARM_EXP2 = 14,
  parameter int WARM_EXP3 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);
  localparam int CNT_W = WARM_EXP3;
  localparam int unsigned N1 = 1 << WARM_EXP1;
  localparam int unsigned N2 = 1 << WARM_EXP2;
  localparam int unsigned N3 = 1 << WARM_EXP3;
  localparam logic [CNT_W-1:0] LD1 = CNT_W'(N1 - 1);
  localparam logic [CNT_W-1:0] LD2 = CNT_W'(N2 - 1);
  localparam logic [CNT_W-1:0] LD3 = CNT_W'(N3 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ld_val;

  always_comb begin
    unique case (sel_i)
      2'b10:   ld_val = LD2;
      2'b11:   ld_val = LD3;
      default: ld_val = LD1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= ld_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/halt_standby_ctrl.sv
module halt_standby_ctrl
  import halt_pkg::*;
#(
  parameter int                 NUM_IRQ   = 16,
  parameter int                 LVL_W     = 3,
  parameter logic [NUM_IRQ-1:0] EXT_WAKE  = 16'h000F,
  parameter int                 WARM_EXP1 = 8,
  parameter int                 WARM_EXP2 = 14,
  parameter int                 WARM_EXP3 = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     halt_req_i,
  input  logic [1:0]               halt_mode_i,
  input  logic [1:0]               warm_sel_i,
  input  logic [NUM_IRQ-1:0]       irq_i,
  input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl_i,
  input  logic [LVL_W-1:0]         irq_mask_i,
  input  logic                     nmi_i,
  output logic                     cpu_run_o,
  output logic                     io_run_o,
  output logic                     osc_run_o,
  output logic [1:0]               wake_act_o
);
  logic [NUM_IRQ-1:0] irq_s;
  logic               nmi_s;

  halt_irq_sync #(.W(NUM_IRQ + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nmi_i, irq_i}),
    .q_o   ({nmi_s, irq_s})
  );

  logic      wake;
  wake_act_e wake_act;

  halt_wake_eval #(
    .NUM_IRQ (NUM_IRQ),
    .LVL_W   (LVL_W),
    .EXT_WAKE(EXT_WAKE)
  ) u_eval (
    .irq_s_i(irq_s),
    .nmi_s_i(nmi_s),
    .lvl_i  (irq_lvl_i),
    .mask_i (irq_mask_i),
    .wake_o (wake),
    .act_o  (wake_act)
  );

  hstate_e    state_q, state_d;
  wake_act_e  act_q, act_d;
  wake_act_e  pend_q, pend_d;
  logic [1:0] warm_sel_q, warm_sel_d;
  logic       warm_load;
  logic       warm_done;

  halt_warm_timer #(
    .WARM_EXP1(WARM_EXP1),
    .WARM_EXP2(WARM_EXP2),
    .WARM_EXP3(WARM_EXP3)
  ) u_warm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(warm_load),
    .sel_i (warm_sel_q),
    .done_o(warm_done)
  );

  always_comb begin
    state_d    = state_q;
    act_d      = ACT_NONE;
    pend_d     = pend_q;
    warm_sel_d = warm_sel_q;
    warm_load  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req_i && halt_mode_i != MODE_RSVD) begin
          warm_sel_d = warm_sel_i;
          unique case (halt_mode_i)
            MODE_CPU: state_d = ST_IDLE_CPU;
            MODE_OSC: state_d = ST_IDLE_OSC;
            default:  state_d = ST_STOP;
          endcase
        end
      end
      ST_IDLE_CPU, ST_IDLE_OSC: begin
        if (wake) begin
          state_d = ST_RUN;
          act_d   = wake_act;
        end
      end
      ST_STOP: begin
        if (wake) begin
          state_d   = ST_WARM;
          pend_d    = wake_act;
          warm_load = 1'b1;
        end
      end
      ST_WARM: begin
        if (warm_done) begin
          state_d = ST_RUN;
          act_d   = pend_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      act_q      <= ACT_NONE;
      pend_q     <= ACT_NONE;
      warm_sel_q <= 2'b00;
    end else begin
      state_q    <= state_d;
      act_q      <= act_d;
      pend_q     <= pend_d;
      warm_sel_q <= warm_sel_d;
    end
  end

  assign cpu_run_o  = (state_q == ST_RUN);
  assign io_run_o   = (state_q == ST_RUN) || (state_q == ST_IDLE_CPU);
  assign osc_run_o  = (state_q != ST_STOP);
  assign wake_act_o = act_q;
endmodule

// File: rtl/halt_standby_chk.sv
module halt_standby_chk
  import halt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_req_i,
  input logic [1:0] halt_mode_i,
  input logic       cpu_run_o,
  input logic       io_run_o,
  input logic       osc_run_o,
  input logic [1:0] wake_act_o,
  input hstate_e    state_q,
  input logic       wake,
  input logic       nmi_s
);
  a_r1_core_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && halt_req_i && halt_mode_i == 2'b11)
      |=> (!cpu_run_o && io_run_o && osc_run_o));

  a_r2_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && halt_req_i && halt_mode_i == 2'b00) |=> cpu_run_o);

  a_r4_stay_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_run_o && state_q != ST_WARM && !wake) |=> !cpu_run_o);

  a_r6_nmi_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_s && (state_q == ST_IDLE_CPU || state_q == ST_IDLE_OSC))
      |=> (cpu_run_o && wake_act_o == 2'b01));

  a_r8_warm_osc_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WARM) |-> (osc_run_o && !io_run_o && !cpu_run_o));

  a_r9_act_on_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_act_o != 2'b00) |-> (cpu_run_o && !$past(cpu_run_o)));

  a_r9_act_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_act_o != 2'b00) |=> (wake_act_o == 2'b00));

  a_r9_act_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_act_o != 2'b11);
endmodule

bind halt_standby_ctrl halt_standby_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_req_i (halt_req_i),
  .halt_mode_i(halt_mode_i),
  .cpu_run_o  (cpu_run_o),
  .io_run_o   (io_run_o),
  .osc_run_o  (osc_run_o),
  .wake_act_o (wake_act_o),
  .state_q    (state_q),
  .wake       (wake),
  .nmi_s      (nmi_s)
);

// File: tb/tb_halt_standby_ctrl.sv
module tb_halt_standby_ctrl;
  localparam int CLK_P = 10;
  localparam int NI = 4;
  localparam int LW = 3;
  localparam logic [NI-1:0] EXT = 4'b0011;
  localparam int E1 = 2;
  localparam int E2 = 3;
  localparam int E3 = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt_req = 1'b0;
  logic [1:0]    halt_mode = 2'b00;
  logic [1:0]    warm_sel = 2'b00;
  logic [NI-1:0] irq = '0;
  logic [NI*LW-1:0] lvl = '0;
  logic [LW-1:0] msk = '0;
  logic          nmi = 1'b0;
  logic          cpu_run, io_run, osc_run;
  logic [1:0]    act;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  halt_standby_ctrl #(
    .NUM_IRQ(NI), .LVL_W(LW), .EXT_WAKE(EXT),
    .WARM_EXP1(E1), .WARM_EXP2(E2), .WARM_EXP3(E3)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .halt_mode_i(halt_mode),
    .warm_sel_i(warm_sel), .irq_i(irq), .irq_lvl_i(lvl), .irq_mask_i(msk),
    .nmi_i(nmi), .cpu_run_o(cpu_run), .io_run_o(io_run), .osc_run_o(osc_run),
    .wake_act_o(act)
  );

  task automatic chk(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int warm_len(input logic [1:0] c);
    case (c)
      2'b10:   return 1 << E2;
      2'b11:   return 1 << E3;
      default: return 1 << E1;
    endcase
  endfunction

  function automatic int dom(input logic [1:0] m);
    case (m)
      2'b11:   return 3'b011;
      2'b10:   return 3'b001;
      2'b01:   return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  // counts negedges until cpu_run returns; stop mode checks osc on the way
  task automatic wait_wake(input logic [1:0] m, input int exp_cyc, input int exp_act,
                           input string req);
    int got = 0;
    int got_act = 0;
    for (int i = 1; i <= 60 && got == 0; i++) begin
      @(negedge clk);
      if (m == 2'b01 && i == 1) chk("R8 osc off before wake", int'(osc_run), 0);
      if (m == 2'b01 && i == 3) chk("R8 osc on in warm-up", int'(osc_run), 1);
      if (cpu_run) begin
        got = i;
        got_act = int'(act);
      end
    end
    chk({req, " wake edge"}, got, exp_cyc);
    chk({req, " wake action"}, got_act, exp_act);
    @(negedge clk);
    chk("R9 action one cycle", int'(act), 0);
  endtask

  task automatic enter_halt(input logic [1:0] m, input logic [1:0] w);
    @(negedge clk);
    halt_req = 1'b1; halt_mode = m; warm_sel = w;
    @(negedge clk);
    halt_req = 1'b0;
    chk("R1 domain enables", int'({cpu_run, io_run, osc_run}), dom(m));
  endtask

  task automatic run_case(input logic [1:0] m, input logic [1:0] w, input int k,
                          input int lv, input int mk);
    int ea;
    int ecyc;
    for (int j = 0; j < NI; j++) lvl[j*LW +: LW] = LW'(lv);
    msk = LW'(mk);
    enter_halt(m, w);
    irq[k] = 1'b1;
    ea = (lv >= mk) ? 1 : (EXT[k] ? 2 : 0);
    ecyc = 3 + ((m == 2'b01) ? warm_len(w) : 0);
    if (ea == 1)      wait_wake(m, ecyc, 1, (m == 2'b01) ? "R3 R8" : "R3 R7");
    else if (ea == 2) wait_wake(m, ecyc, 2, "R5");
    else begin
      repeat (12) @(negedge clk);
      chk("R4 below mask stays halted", int'(cpu_run), 0);
      nmi = 1'b1;
      wait_wake(m, ecyc, 1, "R6");
    end
    irq = '0; nmi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx = 0;
    logic [1:0] modes [3] = '{2'b11, 2'b10, 2'b01};
    #(CLK_P * 3);
    chk("R10 reset enables", int'({cpu_run, io_run, osc_run}), 7);
    chk("R10 reset action", int'(act), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: reserved mode
    @(negedge clk); halt_req = 1'b1; halt_mode = 2'b00;
    @(negedge clk); halt_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reserved mode ignored", int'({cpu_run, io_run, osc_run}), 7);

    // R2: request while halted
    enter_halt(2'b10, 2'b00);
    halt_req = 1'b1; halt_mode = 2'b01;
    @(negedge clk); halt_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 request while halted ignored", int'({cpu_run, io_run, osc_run}), 1);
    nmi = 1'b1;
    wait_wake(2'b10, 3, 1, "R6 R7");
    nmi = 1'b0;
    repeat (4) @(negedge clk);

    for (int mi = 0; mi < 3; mi++)
      for (int k = 0; k < NI; k++)
        for (int lv = 1; lv <= 7; lv++)
          for (int mk = 0; mk <= 7; mk++) begin
            run_case(modes[mi], 2'(idx), k, lv, mk);
            idx++;
          end

    // R10: reset mid-halt
    enter_halt(2'b01, 2'b11);
    #(CLK_P/4) rst_n = 1'b0;
    #1;
    chk("R10 reset releases halt", int'({cpu_run, io_run, osc_run}), 7);
    chk("R10 reset clears action", int'(act), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule